// File: doc/BRIEF.md
# Dual-Bank CPU Register File

This block is the register store for a small 16-bit processor core. Seven general registers exist in two copies: four data registers, two address registers and a frame base. A bank bit inside the flag register picks which copy every access reaches. The file also holds two stack pointers, a static base, a 20-bit vector table base, the flag register and a 20-bit program counter.

Instruction decode supplies a register identifier and an access size on each of two combinational read ports and one registered write port. A size code selects a low byte, a high byte, a 16-bit word or a 32-bit pair. The low two data registers can be split into bytes. Each of those two can also be joined with a partner into a 32-bit pair, and the two address registers form a 32-bit pair in the same way. A generic stack identifier reaches the user or the interrupt stack pointer, as a flag bit selects. The program counter and the flag register also have a dedicated load port and a dedicated output.

Top module: `bcrf_regfile`

## Requirements
- R1: While rst_n is low at a clock edge, every register, both banks, the program counter and the flags are cleared to zero. This selects bank 0 and the interrupt stack pointer.
- R2: The identifiers DAT0=0, DAT1=1, DAT2=2, DAT3=3, ADR0=4, ADR1=5 and FRM=6 reach the bank that flag bit 4 names. The other bank is left untouched.
- R3: Size code 0 is the low byte and size code 1 is the high byte. Both are allowed only on DAT0 and DAT1. Byte write data is taken from wr_data[7:0], and the other half of the register is kept. Byte reads are zero-extended.
- R4: Size code 3 (pair) on DAT0 gives {DAT2,DAT0}, on DAT1 gives {DAT3,DAT1}, and on ADR0 gives {ADR1,ADR0}. The upper register occupies bits 31:16.
- R5: Identifier STK=7 with word size reaches USTK (id 8) when flag bit 7 is 1, and ISTK (id 9) when it is 0. SBAS is id 10.
- R6: The vector table base VTAB (id 11) is 20 bits wide. A word access covers bits 15:0. A high-byte access covers bits 19:16, carried in data bits 3:0. A pair access covers all 20 bits.
- R7: FLAGS (id 12, word size) holds the status and control bits in bits 7:0 and the priority level in bits 14:12. All other bits read as zero and ignore writes.
- R8: flg_we loads flg_wdata into the flags, with the reserved bits cleared. It overrides a general-port write to FLAGS in the same cycle.
- R9: pc_we loads pc_wdata into the 20-bit program counter on the next edge. Without pc_we the counter holds its value.
- R10: A read of a register that is being written in the same cycle returns the old value. A change to flag bit 4 or bit 7 steers accesses from the next cycle on.
- R11: An identifier from 13 to 15, or a size that is not listed for that identifier, reads as zero. A write with such a combination changes nothing.
- R12: The two read ports are independent and may read any register at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | General write enable |
| wr_id | input | 4 | Write register identifier |
| wr_sz | input | 2 | Write size code |
| wr_data | input | 32 | Write data |
| rd0_id | input | 4 | Read port 0 identifier |
| rd0_sz | input | 2 | Read port 0 size code |
| rd0_data | output | 32 | Read port 0 data |
| rd1_id | input | 4 | Read port 1 identifier |
| rd1_sz | input | 2 | Read port 1 size code |
| rd1_data | output | 32 | Read port 1 data |
| pc_we | input | 1 | Program counter load |
| pc_wdata | input | PC_W | Program counter load value |
| pc_q | output | PC_W | Program counter |
| flg_we | input | 1 | Dedicated flag load |
| flg_wdata | input | 16 | Dedicated flag load value |
| flg_q | output | 16 | Flag register |

## Verification
The assertions assume that every control input is a known value at each clock edge while reset is released. They also assume the read identifiers are driven even on cycles when their result is unused. The stimulus changes all inputs only at the falling edge and draws identifiers from the whole 4-bit range, so the unused codes 13 to 15 appear as well. Random values written to FLAGS and to the dedicated flag port toggle the bank and stack select bits freely. This exercises bank and stack switching without any assumption about ordering.

// File: rtl/bcrf_pkg.sv
// Shared identifiers, size codes and flag layout of the banked register file.
// Assumes a 16-bit word; byte access splits the word into two halves.
package bcrf_pkg;
    localparam int NBANKREG = 7;
    localparam int WORD_W   = 16;

    typedef enum logic [3:0] {
        RID_DAT0  = 4'd0,
        RID_DAT1  = 4'd1,
        RID_DAT2  = 4'd2,
        RID_DAT3  = 4'd3,
        RID_ADR0  = 4'd4,
        RID_ADR1  = 4'd5,
        RID_FRM   = 4'd6,
        RID_STK   = 4'd7,
        RID_USTK  = 4'd8,
        RID_ISTK  = 4'd9,
        RID_SBAS  = 4'd10,
        RID_VTAB  = 4'd11,
        RID_FLAGS = 4'd12
    } rid_e;

    typedef enum logic [1:0] {
        SZ_BLO  = 2'd0,
        SZ_BHI  = 2'd1,
        SZ_WORD = 2'd2,
        SZ_PAIR = 2'd3
    } sz_e;

    // Implemented flag bits: low byte plus priority level in 14:12.
    localparam logic [WORD_W-1:0] FLG_MASK = 16'h70FF;
    localparam int FB_BANK = 4;
    localparam int FB_STK  = 7;
endpackage

// File: rtl/bcrf_bank.sv
// One bank of general registers with independent low and high byte enables.
// Assumes the caller has already gated the enables by the active bank.
module bcrf_bank #(
    parameter int NREG = 7,
    parameter int DW   = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NREG-1:0]          be_lo,
    input  logic [NREG-1:0]          be_hi,
    input  logic [NREG-1:0][DW-1:0]  wd,
    output logic [NREG-1:0][DW-1:0]  q
);
    localparam int HALF = DW / 2;

    // Byte-granular storage update with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (be_lo[i]) q[i][HALF-1:0]  <= wd[i][HALF-1:0];
                if (be_hi[i]) q[i][DW-1:HALF] <= wd[i][DW-1:HALF];
            end
        end
    end
endmodule

// File: rtl/bcrf_rdport.sv
// Combinational read port: maps an identifier and a size code onto stored state.
// Assumes gpr already shows the active bank; unsupported combinations give zero.
module bcrf_rdport
    import bcrf_pkg::*;
#(
    parameter int NREG = 7,
    parameter int DW   = 16,
    parameter int TBW  = 20
) (
    input  logic [3:0]               id,
    input  logic [1:0]               sz,
    input  logic [NREG-1:0][DW-1:0]  gpr,
    input  logic [DW-1:0]            usp,
    input  logic [DW-1:0]            isp,
    input  logic [DW-1:0]            sb,
    input  logic [DW-1:0]            flg,
    input  logic [TBW-1:0]           tbl,
    output logic [2*DW-1:0]          rdata
);
    localparam int HALF = DW / 2;

    rid_e rid;
    sz_e  rsz;
    assign rid = rid_e'(id);
    assign rsz = sz_e'(sz);

    // Select and zero-extend the addressed register or register part.
    always_comb begin
        rdata = '0;
        case (rid)
            RID_DAT0, RID_DAT1: begin
                case (rsz)
                    SZ_BLO:  rdata[HALF-1:0] = (rid == RID_DAT0) ? gpr[0][HALF-1:0] : gpr[1][HALF-1:0];
                    SZ_BHI:  rdata[HALF-1:0] = (rid == RID_DAT0) ? gpr[0][DW-1:HALF] : gpr[1][DW-1:HALF];
                    SZ_WORD: rdata[DW-1:0]   = (rid == RID_DAT0) ? gpr[0] : gpr[1];
                    default: rdata = (rid == RID_DAT0) ? {gpr[2], gpr[0]} : {gpr[3], gpr[1]};
                endcase
            end
            RID_DAT2:  if (rsz == SZ_WORD) rdata[DW-1:0] = gpr[2];
            RID_DAT3:  if (rsz == SZ_WORD) rdata[DW-1:0] = gpr[3];
            RID_ADR0: begin
                if (rsz == SZ_WORD)      rdata[DW-1:0] = gpr[4];
                else if (rsz == SZ_PAIR) rdata = {gpr[5], gpr[4]};
            end
            RID_ADR1:  if (rsz == SZ_WORD) rdata[DW-1:0] = gpr[5];
            RID_FRM:   if (rsz == SZ_WORD) rdata[DW-1:0] = gpr[6];
            RID_STK:   if (rsz == SZ_WORD) rdata[DW-1:0] = flg[FB_STK] ? usp : isp;
            RID_USTK:  if (rsz == SZ_WORD) rdata[DW-1:0] = usp;
            RID_ISTK:  if (rsz == SZ_WORD) rdata[DW-1:0] = isp;
            RID_SBAS:  if (rsz == SZ_WORD) rdata[DW-1:0] = sb;
            RID_VTAB: begin
                if (rsz == SZ_WORD)      rdata[DW-1:0]      = tbl[DW-1:0];
                else if (rsz == SZ_BHI)  rdata[TBW-DW-1:0]  = tbl[TBW-1:DW];
                else if (rsz == SZ_PAIR) rdata[TBW-1:0]     = tbl;
            end
            RID_FLAGS: if (rsz == SZ_WORD) rdata[DW-1:0] = flg;
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/bcrf_regfile.sv
// Banked register file top: write decode, two banks, system registers, two read ports.
// Assumes one general write per cycle; the dedicated flag load overrides a general
// FLAGS write. Bank and stack selection use the flag value held before the edge.
module bcrf_regfile
    import bcrf_pkg::*;
#(
    parameter int PC_W = 20
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [3:0]      wr_id,
    input  logic [1:0]      wr_sz,
    input  logic [31:0]     wr_data,
    input  logic [3:0]      rd0_id,
    input  logic [1:0]      rd0_sz,
    output logic [31:0]     rd0_data,
    input  logic [3:0]      rd1_id,
    input  logic [1:0]      rd1_sz,
    output logic [31:0]     rd1_data,
    input  logic            pc_we,
    input  logic [PC_W-1:0] pc_wdata,
    output logic [PC_W-1:0] pc_q,
    input  logic            flg_we,
    input  logic [15:0]     flg_wdata,
    output logic [15:0]     flg_q
);
    localparam int DW    = WORD_W;
    localparam int NREG  = NBANKREG;
    localparam int TBW   = 20;
    localparam int TBH_W = TBW - DW;
    localparam int NBANK = 2;
    localparam int NRD   = 2;

    rid_e wid;
    sz_e  wsz;
    assign wid = rid_e'(wr_id);
    assign wsz = sz_e'(wr_sz);

    logic [NREG-1:0]         g_lo, g_hi;
    logic [NREG-1:0][DW-1:0] g_wd;
    logic                    usp_we, isp_we, sb_we, tbl_lo_we, tbl_hi_we, gflg_we;

    logic [DW-1:0]           usp_q, isp_q, sb_q;
    logic [TBW-1:0]          tbl_q;
    logic                    bank_sel;

    assign bank_sel = flg_q[FB_BANK];

    // Decode the general write into bank byte enables and system register strobes.
    always_comb begin
        g_lo = '0; g_hi = '0; g_wd = '0;
        usp_we = 1'b0; isp_we = 1'b0; sb_we = 1'b0;
        tbl_lo_we = 1'b0; tbl_hi_we = 1'b0; gflg_we = 1'b0;
        if (wr_en) begin
            case (wid)
                RID_DAT0, RID_DAT1: begin
                    for (int k = 0; k < 2; k++) begin
                        if (wid == rid_e'(k)) begin
                            case (wsz)
                                SZ_BLO:  begin g_lo[k] = 1'b1; g_wd[k] = {2{wr_data[7:0]}}; end
                                SZ_BHI:  begin g_hi[k] = 1'b1; g_wd[k] = {2{wr_data[7:0]}}; end
                                SZ_WORD: begin g_lo[k] = 1'b1; g_hi[k] = 1'b1; g_wd[k] = wr_data[DW-1:0]; end
                                default: begin
                                    g_lo[k] = 1'b1; g_hi[k] = 1'b1; g_wd[k] = wr_data[DW-1:0];
                                    g_lo[k+2] = 1'b1; g_hi[k+2] = 1'b1; g_wd[k+2] = wr_data[2*DW-1:DW];
                                end
                            endcase
                        end
                    end
                end
                RID_DAT2, RID_DAT3, RID_ADR1, RID_FRM: begin
                    for (int k = 2; k < NREG; k++) begin
                        if (wid == rid_e'(k) && wsz == SZ_WORD) begin
                            g_lo[k] = 1'b1; g_hi[k] = 1'b1; g_wd[k] = wr_data[DW-1:0];
                        end
                    end
                end
                RID_ADR0: begin
                    if (wsz == SZ_WORD || wsz == SZ_PAIR) begin
                        g_lo[4] = 1'b1; g_hi[4] = 1'b1; g_wd[4] = wr_data[DW-1:0];
                    end
                    if (wsz == SZ_PAIR) begin
                        g_lo[5] = 1'b1; g_hi[5] = 1'b1; g_wd[5] = wr_data[2*DW-1:DW];
                    end
                end
                RID_STK: if (wsz == SZ_WORD) begin
                    usp_we = flg_q[FB_STK];
                    isp_we = !flg_q[FB_STK];
                end
                RID_USTK:  usp_we  = (wsz == SZ_WORD);
                RID_ISTK:  isp_we  = (wsz == SZ_WORD);
                RID_SBAS:  sb_we   = (wsz == SZ_WORD);
                RID_VTAB: begin
                    tbl_lo_we = (wsz == SZ_WORD) || (wsz == SZ_PAIR);
                    tbl_hi_we = (wsz == SZ_BHI)  || (wsz == SZ_PAIR);
                end
                RID_FLAGS: gflg_we = (wsz == SZ_WORD);
                default: ;
            endcase
        end
    end

    logic [NBANK-1:0][NREG-1:0][DW-1:0] bank_q;

    generate
        for (genvar b = 0; b < NBANK; b++) begin : g_bank
            logic en;
            assign en = (bank_sel == b[0]);
            bcrf_bank #(.NREG(NREG), .DW(DW)) u_bank (
                .clk   (clk),
                .rst_n (rst_n),
                .be_lo (en ? g_lo : '0),
                .be_hi (en ? g_hi : '0),
                .wd    (g_wd),
                .q     (bank_q[b])
            );
        end
    endgenerate

    // System registers: stack pointers, static base, vector table base, PC, flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            usp_q <= '0; isp_q <= '0; sb_q <= '0; tbl_q <= '0;
            pc_q  <= '0; flg_q <= '0;
        end else begin
            if (usp_we)    usp_q <= wr_data[DW-1:0];
            if (isp_we)    isp_q <= wr_data[DW-1:0];
            if (sb_we)     sb_q  <= wr_data[DW-1:0];
            if (tbl_lo_we) tbl_q[DW-1:0] <= wr_data[DW-1:0];
            if (tbl_hi_we) tbl_q[TBW-1:DW] <= (wsz == SZ_PAIR) ? wr_data[TBW-1:DW] : wr_data[TBH_W-1:0];
            if (pc_we)     pc_q  <= pc_wdata;
            if (flg_we)       flg_q <= flg_wdata & FLG_MASK;
            else if (gflg_we) flg_q <= wr_data[DW-1:0] & FLG_MASK;
        end
    end

    logic [NREG-1:0][DW-1:0] act_q;
    assign act_q = bank_q[bank_sel];

    logic [NRD-1:0][3:0]  rp_id;
    logic [NRD-1:0][1:0]  rp_sz;
    logic [NRD-1:0][31:0] rp_data;
    assign rp_id = {rd1_id, rd0_id};
    assign rp_sz = {rd1_sz, rd0_sz};
    assign rd0_data = rp_data[0];
    assign rd1_data = rp_data[1];

    generate
        for (genvar p = 0; p < NRD; p++) begin : g_rd
            bcrf_rdport #(.NREG(NREG), .DW(DW), .TBW(TBW)) u_rd (
                .id    (rp_id[p]),
                .sz    (rp_sz[p]),
                .gpr   (act_q),
                .usp   (usp_q),
                .isp   (isp_q),
                .sb    (sb_q),
                .flg   (flg_q),
                .tbl   (tbl_q),
                .rdata (rp_data[p])
            );
        end
    endgenerate
endmodule

// File: rtl/bcrf_chk.sv
// Property checker for the banked register file, attached through bind.
// Observes top-level ports only.
module bcrf_chk
    import bcrf_pkg::*;
#(
    parameter int PC_W = 20
) (
    input logic            clk,
    input logic            rst_n,
    input logic            wr_en,
    input logic [3:0]      wr_id,
    input logic [1:0]      wr_sz,
    input logic [31:0]     wr_data,
    input logic [3:0]      rd0_id,
    input logic [1:0]      rd0_sz,
    input logic [31:0]     rd0_data,
    input logic [3:0]      rd1_id,
    input logic [1:0]      rd1_sz,
    input logic [31:0]     rd1_data,
    input logic            pc_we,
    input logic [PC_W-1:0] pc_wdata,
    input logic [PC_W-1:0] pc_q,
    input logic            flg_we,
    input logic [15:0]     flg_wdata,
    input logic [15:0]     flg_q
);
    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> (flg_q == 16'h0 && pc_q == '0));

    // R9
    pc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |=> pc_q == $past(pc_wdata));

    // R9
    pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pc_we |=> $stable(pc_q));

    // R8
    flag_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flg_we |=> flg_q == ($past(flg_wdata) & FLG_MASK));

    // R7
    flag_general_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flg_we && wr_en && wr_id == 4'd12 && wr_sz == 2'd2) |=> flg_q == ($past(wr_data[15:0]) & FLG_MASK));

    // R7
    flag_reserved_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flg_q & ~FLG_MASK) == 16'h0);

    // R12
    read_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd1_id == 4'd12 && rd1_sz == 2'd2) |-> rd1_data == {16'h0, flg_q});

    // R11
    read_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd0_id >= 4'd13) |-> rd0_data == 32'h0);
endmodule

bind bcrf_regfile bcrf_chk #(.PC_W(PC_W)) u_chk (.*);

// File: tb/tb_bcrf_regfile.sv
// Random plus directed bench for the banked register file with a reference model.
module tb_bcrf_regfile;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W       = 20;
    localparam int NRAND      = 4000;
    localparam logic [15:0] MASK = 16'h70FF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            wr_en = 1'b0;
    logic [3:0]      wr_id = '0;
    logic [1:0]      wr_sz = '0;
    logic [31:0]     wr_data = '0;
    logic [3:0]      rd0_id = '0, rd1_id = '0;
    logic [1:0]      rd0_sz = '0, rd1_sz = '0;
    logic [31:0]     rd0_data, rd1_data;
    logic            pc_we = 1'b0;
    logic [PC_W-1:0] pc_wdata = '0;
    logic [PC_W-1:0] pc_q;
    logic            flg_we = 1'b0;
    logic [15:0]     flg_wdata = '0;
    logic [15:0]     flg_q;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcrf_regfile #(.PC_W(PC_W)) dut (.*);

    // Reference state.
    logic [15:0] mb [2][7];
    logic [15:0] musp, misp, msb, mflg;
    logic [19:0] mtb, mpc;

    task automatic mreset();
        for (int b = 0; b < 2; b++) for (int i = 0; i < 7; i++) mb[b][i] = '0;
        musp = '0; misp = '0; msb = '0; mflg = '0; mtb = '0; mpc = '0;
    endtask

    function automatic logic [31:0] mread(input logic [3:0] id, input logic [1:0] sz);
        int bk;
        bk = mflg[4];
        mread = '0;
        case (id)
            4'd0, 4'd1: case (sz)
                2'd0: mread = {24'h0, mb[bk][id][7:0]};
                2'd1: mread = {24'h0, mb[bk][id][15:8]};
                2'd2: mread = {16'h0, mb[bk][id]};
                default: mread = {mb[bk][id+2], mb[bk][id]};
            endcase
            4'd2, 4'd3, 4'd5, 4'd6: if (sz == 2'd2) mread = {16'h0, mb[bk][id]};
            4'd4: if (sz == 2'd2) mread = {16'h0, mb[bk][4]};
                  else if (sz == 2'd3) mread = {mb[bk][5], mb[bk][4]};
            4'd7: if (sz == 2'd2) mread = {16'h0, mflg[7] ? musp : misp};
            4'd8: if (sz == 2'd2) mread = {16'h0, musp};
            4'd9: if (sz == 2'd2) mread = {16'h0, misp};
            4'd10: if (sz == 2'd2) mread = {16'h0, msb};
            4'd11: if (sz == 2'd2) mread = {16'h0, mtb[15:0]};
                   else if (sz == 2'd1) mread = {28'h0, mtb[19:16]};
                   else if (sz == 2'd3) mread = {12'h0, mtb};
            4'd12: if (sz == 2'd2) mread = {16'h0, mflg};
            default: mread = '0;
        endcase
    endfunction

    task automatic mwrite();
        int bk;
        bk = mflg[4];
        if (!wr_en) return;
        case (wr_id)
            4'd0, 4'd1: case (wr_sz)
                2'd0: mb[bk][wr_id][7:0]  = wr_data[7:0];
                2'd1: mb[bk][wr_id][15:8] = wr_data[7:0];
                2'd2: mb[bk][wr_id] = wr_data[15:0];
                default: begin mb[bk][wr_id] = wr_data[15:0]; mb[bk][wr_id+2] = wr_data[31:16]; end
            endcase
            4'd2, 4'd3, 4'd5, 4'd6: if (wr_sz == 2'd2) mb[bk][wr_id] = wr_data[15:0];
            4'd4: if (wr_sz == 2'd2) mb[bk][4] = wr_data[15:0];
                  else if (wr_sz == 2'd3) begin mb[bk][4] = wr_data[15:0]; mb[bk][5] = wr_data[31:16]; end
            4'd7: if (wr_sz == 2'd2) begin if (mflg[7]) musp = wr_data[15:0]; else misp = wr_data[15:0]; end
            4'd8: if (wr_sz == 2'd2) musp = wr_data[15:0];
            4'd9: if (wr_sz == 2'd2) misp = wr_data[15:0];
            4'd10: if (wr_sz == 2'd2) msb = wr_data[15:0];
            4'd11: if (wr_sz == 2'd2) mtb[15:0] = wr_data[15:0];
                   else if (wr_sz == 2'd1) mtb[19:16] = wr_data[3:0];
                   else if (wr_sz == 2'd3) mtb = wr_data[19:0];
            4'd12: if (wr_sz == 2'd2) mflg = wr_data[15:0] & MASK;
            default: ;
        endcase
    endtask

    function automatic string tag_of(input logic [3:0] id, input logic [1:0] sz);
        if (id >= 4'd13) return "R11";
        if (id <= 4'd1 && sz <= 2'd1) return "R3";
        if (sz == 2'd3 && (id <= 4'd1 || id == 4'd4)) return "R4";
        if (id >= 4'd7 && id <= 4'd10) return "R5";
        if (id == 4'd11) return "R6";
        if (id == 4'd12) return "R7";
        if (sz != 2'd2) return "R11";
        return "R2";
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare outputs mid-cycle, then advance one clock and update the model.
    task automatic step();
        #1;
        chk(tag_of(rd0_id, rd0_sz), rd0_data, mread(rd0_id, rd0_sz));
        chk({"R12 ", tag_of(rd1_id, rd1_sz)}, rd1_data, mread(rd1_id, rd1_sz));
        chk("R9", {12'h0, pc_q}, {12'h0, mpc});
        chk("R8", {16'h0, flg_q}, {16'h0, mflg});
        @(posedge clk);
        mwrite();
        if (pc_we) mpc = pc_wdata;
        if (flg_we) mflg = flg_wdata & MASK;
        @(negedge clk);
    endtask

    task automatic idle();
        wr_en = 1'b0; pc_we = 1'b0; flg_we = 1'b0;
    endtask

    task automatic gwrite(input logic [3:0] id, input logic [1:0] sz, input logic [31:0] d);
        idle();
        wr_en = 1'b1; wr_id = id; wr_sz = sz; wr_data = d;
        step();
        idle();
    endtask

    task automatic peek(input string tag, input logic [3:0] id, input logic [1:0] sz, input logic [31:0] exp);
        rd0_id = id; rd0_sz = sz;
        #1;
        chk(tag, rd0_data, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        mreset();
        // R1: load junk under reset, then check the cleared state.
        @(negedge clk);
        pc_we = 1'b1; pc_wdata = 20'hABCDE; flg_we = 1'b1; flg_wdata = 16'hFFFF;
        @(negedge clk);
        @(negedge clk);
        idle();
        #1;
        chk("R1", {12'h0, pc_q}, 32'h0);
        chk("R1", {16'h0, flg_q}, 32'h0);
        rst_n = 1'b1;
        peek("R1", 4'd0, 2'd2, 32'h0);

        // R3: byte writes keep the other half.
        gwrite(4'd0, 2'd2, 32'h0000A5C3);
        gwrite(4'd0, 2'd0, 32'h00000011);
        peek("R3", 4'd0, 2'd2, 32'h0000A511);
        gwrite(4'd0, 2'd1, 32'h0000007E);
        peek("R3", 4'd0, 2'd2, 32'h00007E11);
        peek("R3", 4'd0, 2'd1, 32'h0000007E);

        // R4: pair write lands in the partner register.
        gwrite(4'd1, 2'd3, 32'hCAFE1234);
        peek("R4", 4'd3, 2'd2, 32'h0000CAFE);
        gwrite(4'd4, 2'd3, 32'h55AA0F0F);
        peek("R4", 4'd5, 2'd2, 32'h000055AA);

        // R10: read during write returns the old value.
        wr_en = 1'b1; wr_id = 4'd1; wr_sz = 2'd2; wr_data = 32'h00005678;
        peek("R10", 4'd1, 2'd2, 32'h00001234);
        step();
        idle();
        peek("R10", 4'd1, 2'd2, 32'h00005678);

        // R2: switch to bank 1; bank 0 value hidden, then visible again.
        gwrite(4'd12, 2'd2, 32'h00000010);
        peek("R2", 4'd0, 2'd2, 32'h00000000);
        gwrite(4'd0, 2'd2, 32'h0000BEEF);
        gwrite(4'd12, 2'd2, 32'h00000000);
        peek("R2", 4'd0, 2'd2, 32'h00007E11);

        // R5: stack pointer selection follows bit 7.
        gwrite(4'd7, 2'd2, 32'h00001111);
        peek("R5", 4'd9, 2'd2, 32'h00001111);
        gwrite(4'd12, 2'd2, 32'h00000080);
        gwrite(4'd7, 2'd2, 32'h00002222);
        peek("R5", 4'd8, 2'd2, 32'h00002222);
        peek("R5", 4'd9, 2'd2, 32'h00001111);

        // R6: table base parts.
        gwrite(4'd11, 2'd2, 32'h0000BEAD);
        gwrite(4'd11, 2'd1, 32'h000000F9);
        peek("R6", 4'd11, 2'd3, 32'h0009BEAD);

        // R7: reserved flag bits dropped.
        gwrite(4'd12, 2'd2, 32'hFFFFFFFF);
        peek("R7", 4'd12, 2'd2, 32'h000070FF);

        // R8: dedicated flag load wins over the general port.
        wr_en = 1'b1; wr_id = 4'd12; wr_sz = 2'd2; wr_data = 32'h00000010;
        flg_we = 1'b1; flg_wdata = 16'h8080;
        step();
        idle();
        chk("R8", {16'h0, flg_q}, 32'h00000080);

        // R11: invalid combinations ignored.
        gwrite(4'd2, 2'd0, 32'h000000AB);
        peek("R11", 4'd2, 2'd2, 32'h00000000);
        gwrite(4'd14, 2'd2, 32'hFFFFFFFF);
        peek("R11", 4'd14, 2'd2, 32'h00000000);
        peek("R11", 4'd0, 2'd2, 32'h00007E11);

        // R9: program counter load and hold.
        pc_we = 1'b1; pc_wdata = 20'h12345;
        step();
        idle();
        step();
        chk("R9", {12'h0, pc_q}, 32'h00012345);

        // Random mix checked against the model.
        for (int n = 0; n < NRAND; n++) begin
            wr_en     = ($urandom_range(0, 9) < 7);
            wr_id     = 4'($urandom_range(0, 15));
            wr_sz     = 2'($urandom_range(0, 3));
            wr_data   = $urandom;
            rd0_id    = 4'($urandom_range(0, 15));
            rd0_sz    = 2'($urandom_range(0, 3));
            rd1_id    = 4'($urandom_range(0, 15));
            rd1_sz    = 2'($urandom_range(0, 3));
            pc_we     = ($urandom_range(0, 9) < 3);
            pc_wdata  = 20'($urandom);
            flg_we    = ($urandom_range(0, 19) == 0);
            flg_wdata = 16'($urandom);
            step();
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule